// File: doc/BRIEF.md
# Two-Table Opcode Decoder for an 8-bit Accumulator CPU

This block turns a stream of opcode bytes into a decoded description of each instruction. One byte is offered per cycle with a valid strobe. One clock later the block presents registered fields: an operation class, a destination and a source selector, a sub-operation index, a condition code, a restart target and the raw byte. It also shows whether the byte was decoded with the secondary table.

The decoder cuts every byte into x = bits 7:6, y = bits 5:3, z = bits 2:0, p = bits 5:4 and q = bit 3. Byte 0xCB is the prefix. It arms a single state bit, and the next accepted byte is decoded with the secondary bit/shift/rotate table. Slots that a classic decode of this field split would fill with conditionals or port I/O are remapped here. They become high-page loads, stack-pointer offset operations, or invalid codes that pass the raw byte through.

Fetching immediates, executing instructions, sequencing cycles and handling interrupts belong to the surrounding core.

Top module: `opdec_top`

## Requirements
- R1: Class encoding. HALT=10, LD8=5, ALU=11, RST=25, INVALID=26. Register selector codes 0..7 are the value of the y or z field, with 7 meaning the accumulator. Condition 4 means unconditional, and any field a class does not use reads 0 (the condition field reads 4). Byte 0x76 is HALT. Every other x=1 byte is LD8 with dst=y and src=z.
- R2: x=2 is ALU with sub=y, dst=7 and src=z. x=3, z=6 is ALU with sub=y, dst=7 and src=8 (the 8-bit immediate).
- R3: x=3, z=7 is RST, with vec equal to y times 8.
- R4: Slot x=3, z=0 (codes 13 = high page plus immediate, 8 = imm8, 3 = SP, 2 = HL; classes RET=15, ADDSP=22, LDHLSP=23):
  - y=0..3 is RET with cond=y (0 NZ, 1 Z, 2 NC, 3 C).
  - y=4 is LD8 with dst=13, src=7.
  - y=5 is ADDSP with dst=3, src=8.
  - y=6 is LD8 with dst=7, src=13.
  - y=7 is LDHLSP with dst=2, src=3.
- R5: Slot x=3, z=2 (codes 14 = high page plus C, 15 = absolute immediate address; JP=14):
  - y=0..3 is JP with cond=y and src=5 (the 16-bit immediate).
  - y=4 is LD8 with dst=14, src=7.
  - y=5 is LD8 with dst=15, src=7.
  - y=6 is LD8 with dst=7, src=14.
  - y=7 is LD8 with dst=7, src=15.
- R6: These bytes are INVALID with all selector fields 0, and out_raw carries the byte:
  - x=3, z=3 with y=2..5.
  - x=3, z=4 with y=4..7.
  - x=3, z=5 with q=1 and p=1..3.
- R7: A primary 0xCB is reported as PREFIX=18 with out_sec=0, and the next accepted byte is decoded with the secondary table and out_sec=1. Secondary classes by x:
  - x=0 is SHIFT=27 with sub=y and dst=src=z.
  - x=1 is BITTEST=28 with sub=y, src=z and dst=0.
  - x=2 is BITCLR=29 with sub=y and dst=src=z.
  - x=3 is BITSET=30 with sub=y and dst=src=z.
- R8: The prefix state lasts for exactly one accepted byte. Cycles with in_valid low leave it unchanged. A 0xCB received while armed decodes as a secondary byte (BITSET, sub=1, dst=src=3) and does not re-arm the state.
- R9: 0xF3 decodes as DI=19 and 0xFB decodes as EI=20.
- R10: Slot x=0, z=0 (NOP=0, LD16=8, STOP=1, JR=2):
  - y=0 is NOP.
  - y=1 is LD16 with dst=6 (absolute address) and src=3 (SP).
  - y=2 is STOP.
  - y=3..7 is JR with src=8 and cond=4 for y=3, otherwise cond=y-4.
- R11: Synchronous reset clears out_valid and the prefix state, so a byte after reset decodes with the primary table.
- R12: out_valid is high exactly in the cycle after an accepted byte, and the fields belong to that byte.
- R13: Remaining x=0 and x=3 rows (pair codes 0 BC, 1 DE, 2 HL, 3 SP, 4 AF, 5 imm16; indirect codes 9 + p):
  - z=1, q=0 is LD16 with dst=p, src=5.
  - z=1, q=1 is ADD16=9 with dst=2, src=p.
  - z=2 is LD8 between A and 9+p (q=0 stores A, q=1 loads A).
  - z=3 is INC16=6 or DEC16=7 with dst=p.
  - z=4 is INC8=3 with dst=y.
  - z=7 is ALU1=12 with sub=y.
  - x=3, z=5, q=0 is PUSH=16 with src=p, AF replacing SP.
  - x=3, z=1, q=0 is POP=17 with dst=p, AF replacing SP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Opcode byte |
| out_valid | output | 1 | Decoded fields valid |
| out_class | output | 5 | Operation class code |
| out_dst | output | 4 | Destination selector |
| out_src | output | 4 | Source selector |
| out_sub | output | 3 | ALU op, shift kind or bit index |
| out_cond | output | 3 | Condition (4 = unconditional) |
| out_vec | output | 8 | Restart target address |
| out_sec | output | 1 | Byte decoded with the secondary table |
| out_raw | output | 8 | Raw byte echoed |

## Verification
The prefix state can be cleared by a consumed secondary byte in the same cycle that a 0xCB arrives. The question in that cycle is whether the 0xCB re-arms the state. The bench provokes this with back-to-back 0xCB bytes followed by 0x00. It expects the second 0xCB as a secondary BITSET and the 0x00 as a primary NOP. It also holds the prefix across idle cycles, and it applies reset while the prefix is armed to confirm the state does not survive.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

    localparam int BYTE_W  = 8;
    localparam int CLASS_W = 5;
    localparam int SEL_W   = 4;
    localparam int SUB_W   = 3;
    localparam int COND_W  = 3;

    typedef enum logic [CLASS_W-1:0] {
        OC_NOP     = 5'd0,
        OC_STOP    = 5'd1,
        OC_JR      = 5'd2,
        OC_INC8    = 5'd3,
        OC_DEC8    = 5'd4,
        OC_LD8     = 5'd5,
        OC_INC16   = 5'd6,
        OC_DEC16   = 5'd7,
        OC_LD16    = 5'd8,
        OC_ADD16   = 5'd9,
        OC_HALT    = 5'd10,
        OC_ALU     = 5'd11,
        OC_ALU1    = 5'd12,
        OC_CALL    = 5'd13,
        OC_JP      = 5'd14,
        OC_RET     = 5'd15,
        OC_PUSH    = 5'd16,
        OC_POP     = 5'd17,
        OC_PREFIX  = 5'd18,
        OC_DI      = 5'd19,
        OC_EI      = 5'd20,
        OC_RETI    = 5'd21,
        OC_ADDSP   = 5'd22,
        OC_LDHLSP  = 5'd23,
        OC_JPHL    = 5'd24,
        OC_RST     = 5'd25,
        OC_INVALID = 5'd26,
        OC_SHIFT   = 5'd27,
        OC_BITTEST = 5'd28,
        OC_BITCLR  = 5'd29,
        OC_BITSET  = 5'd30
    } op_class_e;

    // 8-bit operand selectors beyond the register codes 0..7
    localparam logic [SEL_W-1:0] SEL_A      = 4'd7;
    localparam logic [SEL_W-1:0] SEL_IMM8   = 4'd8;
    localparam logic [SEL_W-1:0] SEL_IND0   = 4'd9;
    localparam logic [SEL_W-1:0] SEL_HI_IMM = 4'd13;
    localparam logic [SEL_W-1:0] SEL_HI_C   = 4'd14;
    localparam logic [SEL_W-1:0] SEL_ABS8   = 4'd15;

    // 16-bit operand selectors
    localparam logic [SEL_W-1:0] PR_HL    = 4'd2;
    localparam logic [SEL_W-1:0] PR_SP    = 4'd3;
    localparam logic [SEL_W-1:0] PR_AF    = 4'd4;
    localparam logic [SEL_W-1:0] PR_IMM16 = 4'd5;
    localparam logic [SEL_W-1:0] PR_ABS   = 4'd6;

    localparam logic [COND_W-1:0] CC_ALWAYS = 3'd4;

    localparam logic [BYTE_W-1:0] PREFIX_BYTE = 8'hCB;

    typedef struct packed {
        op_class_e           cls;
        logic [SEL_W-1:0]    dst;
        logic [SEL_W-1:0]    src;
        logic [SUB_W-1:0]    sub;
        logic [COND_W-1:0]   cond;
        logic [BYTE_W-1:0]   vec;
    } dec_t;

    function automatic dec_t dec_blank();
        dec_t d;
        d.cls  = OC_INVALID;
        d.dst  = '0;
        d.src  = '0;
        d.sub  = '0;
        d.cond = CC_ALWAYS;
        d.vec  = '0;
        return d;
    endfunction

    // pair code for push/pop: slot 3 names AF instead of SP
    function automatic logic [SEL_W-1:0] pair_af(input logic [1:0] p);
        return (p == 2'd3) ? PR_AF : {2'b00, p};
    endfunction

    function automatic logic [SEL_W-1:0] pair_sp(input logic [1:0] p);
        return {2'b00, p};
    endfunction

endpackage

// File: rtl/opdec_primary.sv
module opdec_primary
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output dec_t              dec_o
);
    logic [1:0] x, p;
    logic [2:0] y, z;
    logic       q;

    assign x = byte_i[7:6];
    assign y = byte_i[5:3];
    assign z = byte_i[2:0];
    assign p = byte_i[5:4];
    assign q = byte_i[3];

    always_comb begin
        dec_o = dec_blank();
        unique case (x)
            2'd0: begin
                unique case (z)
                    3'd0: begin
                        if (y == 3'd0) begin
                            dec_o.cls = OC_NOP;
                        end else if (y == 3'd1) begin
                            dec_o.cls = OC_LD16;
                            dec_o.dst = PR_ABS;
                            dec_o.src = PR_SP;
                        end else if (y == 3'd2) begin
                            dec_o.cls = OC_STOP;
                        end else begin
                            dec_o.cls  = OC_JR;
                            dec_o.src  = SEL_IMM8;
                            dec_o.cond = (y == 3'd3) ? CC_ALWAYS : (y - 3'd4);
                        end
                    end
                    3'd1: begin
                        if (!q) begin
                            dec_o.cls = OC_LD16;
                            dec_o.dst = pair_sp(p);
                            dec_o.src = PR_IMM16;
                        end else begin
                            dec_o.cls = OC_ADD16;
                            dec_o.dst = PR_HL;
                            dec_o.src = pair_sp(p);
                        end
                    end
                    3'd2: begin
                        dec_o.cls = OC_LD8;
                        if (!q) begin
                            dec_o.dst = SEL_IND0 + {2'b00, p};
                            dec_o.src = SEL_A;
                        end else begin
                            dec_o.dst = SEL_A;
                            dec_o.src = SEL_IND0 + {2'b00, p};
                        end
                    end
                    3'd3: begin
                        dec_o.cls = q ? OC_DEC16 : OC_INC16;
                        dec_o.dst = pair_sp(p);
                    end
                    3'd4: begin
                        dec_o.cls = OC_INC8;
                        dec_o.dst = {1'b0, y};
                    end
                    3'd5: begin
                        dec_o.cls = OC_DEC8;
                        dec_o.dst = {1'b0, y};
                    end
                    3'd6: begin
                        dec_o.cls = OC_LD8;
                        dec_o.dst = {1'b0, y};
                        dec_o.src = SEL_IMM8;
                    end
                    default: begin
                        dec_o.cls = OC_ALU1;
                        dec_o.sub = y;
                    end
                endcase
            end
            2'd1: begin
                if (y == 3'd6 && z == 3'd6) begin
                    dec_o.cls = OC_HALT;
                end else begin
                    dec_o.cls = OC_LD8;
                    dec_o.dst = {1'b0, y};
                    dec_o.src = {1'b0, z};
                end
            end
            2'd2: begin
                dec_o.cls = OC_ALU;
                dec_o.sub = y;
                dec_o.dst = SEL_A;
                dec_o.src = {1'b0, z};
            end
            default: begin
                unique case (z)
                    3'd0: begin
                        unique case (y)
                            3'd4: begin dec_o.cls = OC_LD8; dec_o.dst = SEL_HI_IMM; dec_o.src = SEL_A; end
                            3'd5: begin dec_o.cls = OC_ADDSP; dec_o.dst = PR_SP; dec_o.src = SEL_IMM8; end
                            3'd6: begin dec_o.cls = OC_LD8; dec_o.dst = SEL_A; dec_o.src = SEL_HI_IMM; end
                            3'd7: begin dec_o.cls = OC_LDHLSP; dec_o.dst = PR_HL; dec_o.src = PR_SP; end
                            default: begin dec_o.cls = OC_RET; dec_o.cond = y; end
                        endcase
                    end
                    3'd1: begin
                        if (!q) begin
                            dec_o.cls = OC_POP;
                            dec_o.dst = pair_af(p);
                        end else begin
                            unique case (p)
                                2'd0: dec_o.cls = OC_RET;
                                2'd1: dec_o.cls = OC_RETI;
                                2'd2: begin dec_o.cls = OC_JPHL; dec_o.src = PR_HL; end
                                default: begin dec_o.cls = OC_LD16; dec_o.dst = PR_SP; dec_o.src = PR_HL; end
                            endcase
                        end
                    end
                    3'd2: begin
                        unique case (y)
                            3'd4: begin dec_o.cls = OC_LD8; dec_o.dst = SEL_HI_C; dec_o.src = SEL_A; end
                            3'd5: begin dec_o.cls = OC_LD8; dec_o.dst = SEL_ABS8; dec_o.src = SEL_A; end
                            3'd6: begin dec_o.cls = OC_LD8; dec_o.dst = SEL_A; dec_o.src = SEL_HI_C; end
                            3'd7: begin dec_o.cls = OC_LD8; dec_o.dst = SEL_A; dec_o.src = SEL_ABS8; end
                            default: begin dec_o.cls = OC_JP; dec_o.cond = y; dec_o.src = PR_IMM16; end
                        endcase
                    end
                    3'd3: begin
                        if (y == 3'd0) begin
                            dec_o.cls = OC_JP;
                            dec_o.src = PR_IMM16;
                        end else if (y == 3'd1) begin
                            dec_o.cls = OC_PREFIX;
                        end else if (y == 3'd6) begin
                            dec_o.cls = OC_DI;
                        end else if (y == 3'd7) begin
                            dec_o.cls = OC_EI;
                        end
                    end
                    3'd4: begin
                        if (!y[2]) begin
                            dec_o.cls  = OC_CALL;
                            dec_o.cond = y;
                            dec_o.src  = PR_IMM16;
                        end
                    end
                    3'd5: begin
                        if (!q) begin
                            dec_o.cls = OC_PUSH;
                            dec_o.src = pair_af(p);
                        end else if (p == 2'd0) begin
                            dec_o.cls = OC_CALL;
                            dec_o.src = PR_IMM16;
                        end
                    end
                    3'd6: begin
                        dec_o.cls = OC_ALU;
                        dec_o.sub = y;
                        dec_o.dst = SEL_A;
                        dec_o.src = SEL_IMM8;
                    end
                    default: begin
                        dec_o.cls = OC_RST;
                        dec_o.vec = {2'b00, y, 3'b000};
                    end
                endcase
            end
        endcase
    end
endmodule

// File: rtl/opdec_secondary.sv
module opdec_secondary
    import opdec_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output dec_t              dec_o
);
    logic [2:0] y, z;

    assign y = byte_i[5:3];
    assign z = byte_i[2:0];

    always_comb begin
        dec_o     = dec_blank();
        dec_o.sub = y;
        dec_o.src = {1'b0, z};
        unique case (byte_i[7:6])
            2'd0: begin dec_o.cls = OC_SHIFT;   dec_o.dst = {1'b0, z}; end
            2'd1: begin dec_o.cls = OC_BITTEST; end
            2'd2: begin dec_o.cls = OC_BITCLR;  dec_o.dst = {1'b0, z}; end
            default: begin dec_o.cls = OC_BITSET; dec_o.dst = {1'b0, z}; end
        endcase
    end
endmodule

// File: rtl/opdec_prefix_state.sv
module opdec_prefix_state
    import opdec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ARM_BYTE = PREFIX_BYTE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              armed_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            armed_o <= 1'b0;
        end else if (in_valid) begin
            // an armed state always consumes the byte, even another prefix
            armed_o <= !armed_o && (in_byte == ARM_BYTE);
        end
    end
endmodule

// File: rtl/opdec_top.sv
module opdec_top
    import opdec_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    output logic               out_valid,
    output logic [4:0]         out_class,
    output logic [3:0]         out_dst,
    output logic [3:0]         out_src,
    output logic [2:0]         out_sub,
    output logic [2:0]         out_cond,
    output logic [7:0]         out_vec,
    output logic               out_sec,
    output logic [7:0]         out_raw
);
    dec_t pri_dec, sec_dec, dec_q;
    logic prefix_q;

    opdec_primary u_pri (
        .byte_i (in_byte),
        .dec_o  (pri_dec)
    );

    opdec_secondary u_sec (
        .byte_i (in_byte),
        .dec_o  (sec_dec)
    );

    opdec_prefix_state #(.ARM_BYTE(PREFIX_BYTE)) u_pfx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .armed_o  (prefix_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dec_q     <= dec_blank();
            out_sec   <= 1'b0;
            out_raw   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                dec_q   <= prefix_q ? sec_dec : pri_dec;
                out_sec <= prefix_q;
                out_raw <= in_byte;
            end
        end
    end

    assign out_class = dec_q.cls;
    assign out_dst   = dec_q.dst;
    assign out_src   = dec_q.src;
    assign out_sub   = dec_q.sub;
    assign out_cond  = dec_q.cond;
    assign out_vec   = dec_q.vec;
endmodule

// File: rtl/opdec_chk.sv
module opdec_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       out_valid,
    input logic [4:0] out_class,
    input logic [7:0] out_vec,
    input logic       out_sec,
    input logic       prefix_q
);
    // R12
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R12
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R7
    prefix_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !prefix_q && in_byte == 8'hCB) |=> prefix_q);

    // R8
    prefix_once_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && prefix_q) |=> (!prefix_q && out_sec));

    // R8
    prefix_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(prefix_q));

    // R3
    rst_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_sec && out_class == 5'd25) |-> (out_vec[2:0] == 3'd0 && out_vec[7:6] == 2'd0));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !prefix_q));
endmodule

bind opdec_top opdec_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_byte   (in_byte),
    .out_valid (out_valid),
    .out_class (out_class),
    .out_vec   (out_vec),
    .out_sec   (out_sec),
    .prefix_q  (prefix_q)
);

// File: tb/opdec_top_test.sv
module opdec_top_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       out_valid;
    logic [4:0] out_class;
    logic [3:0] out_dst, out_src;
    logic [2:0] out_sub, out_cond;
    logic [7:0] out_vec, out_raw;
    logic       out_sec;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [35:0] v;
        string       req;
    } item_t;

    item_t sb[$];

    always #(CLK_P/2) clk = ~clk;

    opdec_top uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .out_valid(out_valid), .out_class(out_class), .out_dst(out_dst),
        .out_src(out_src), .out_sub(out_sub), .out_cond(out_cond),
        .out_vec(out_vec), .out_sec(out_sec), .out_raw(out_raw)
    );

    function automatic logic [35:0] pack(input logic [4:0] c, input logic [3:0] d, input logic [3:0] s,
                                         input logic [2:0] sb_, input logic [2:0] cc, input logic [7:0] vec,
                                         input logic sec, input logic [7:0] raw);
        return {c, d, s, sb_, cc, vec, sec, raw};
    endfunction

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // driver: one byte at the next falling edge, expectation queued
    task automatic send(input logic [7:0] b, input logic [4:0] c, input logic [3:0] d, input logic [3:0] s,
                        input logic [2:0] sub, input logic [2:0] cc, input logic [7:0] vec,
                        input logic sec, input string req);
        item_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        it.v   = pack(c, d, s, sub, cc, vec, sec, b);
        it.req = req;
        sb.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_byte  = 8'hCB;
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            logic [35:0] act;
            act = {out_class, out_dst, out_src, out_sub, out_cond, out_vec, out_sec, out_raw};
            if (sb.size() == 0) begin
                check(1'b0, "R12 unexpected output", act, 36'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(act == it.v, it.req, act, it.v);
            end
        end
    end

    initial begin
        #(CLK_P * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R11 reset out_valid", {35'h0, out_valid}, 36'h0);
        rst = 1'b0;
        idle(1);

        // R1
        send(8'h76, 10, 0, 0, 0, 4, 0, 0, "R1 halt");
        send(8'h41, 5, 0, 1, 0, 4, 0, 0, "R1 ld b,c");
        send(8'h7E, 5, 7, 6, 0, 4, 0, 0, "R1 ld a,(hl)");
        // R2
        send(8'h90, 11, 7, 0, 2, 4, 0, 0, "R2 alu reg");
        send(8'hFE, 11, 7, 8, 7, 4, 0, 0, "R2 alu imm");
        // R3
        send(8'hEF, 25, 0, 0, 0, 4, 8'h28, 0, "R3 rst 28");
        send(8'hC7, 25, 0, 0, 0, 4, 8'h00, 0, "R3 rst 00");
        send(8'hFF, 25, 0, 0, 0, 4, 8'h38, 0, "R3 rst 38");
        // R4
        send(8'hE0, 5, 13, 7, 0, 4, 0, 0, "R4 store high imm");
        send(8'hE8, 22, 3, 8, 0, 4, 0, 0, "R4 add sp");
        send(8'hF0, 5, 7, 13, 0, 4, 0, 0, "R4 load high imm");
        send(8'hF8, 23, 2, 3, 0, 4, 0, 0, "R4 hl=sp+off");
        send(8'hD8, 15, 0, 0, 0, 3, 0, 0, "R4 ret c");
        send(8'hC0, 15, 0, 0, 0, 0, 0, 0, "R4 ret nz");
        // R5
        send(8'hE2, 5, 14, 7, 0, 4, 0, 0, "R5 store high c");
        send(8'hEA, 5, 15, 7, 0, 4, 0, 0, "R5 store abs");
        send(8'hF2, 5, 7, 14, 0, 4, 0, 0, "R5 load high c");
        send(8'hFA, 5, 7, 15, 0, 4, 0, 0, "R5 load abs");
        send(8'hCA, 14, 0, 5, 0, 1, 0, 0, "R5 jp z");
        // R6
        send(8'hD3, 26, 0, 0, 0, 4, 0, 0, "R6 invalid d3");
        send(8'hEB, 26, 0, 0, 0, 4, 0, 0, "R6 invalid eb");
        send(8'hE4, 26, 0, 0, 0, 4, 0, 0, "R6 invalid e4");
        send(8'hFC, 26, 0, 0, 0, 4, 0, 0, "R6 invalid fc");
        send(8'hDD, 26, 0, 0, 0, 4, 0, 0, "R6 invalid dd");
        send(8'hFD, 26, 0, 0, 0, 4, 0, 0, "R6 invalid fd");
        // R9
        send(8'hF3, 19, 0, 0, 0, 4, 0, 0, "R9 di");
        send(8'hFB, 20, 0, 0, 0, 4, 0, 0, "R9 ei");
        // R10
        send(8'h00, 0, 0, 0, 0, 4, 0, 0, "R10 nop");
        send(8'h08, 8, 6, 3, 0, 4, 0, 0, "R10 store sp");
        send(8'h10, 1, 0, 0, 0, 4, 0, 0, "R10 stop");
        send(8'h18, 2, 0, 8, 0, 4, 0, 0, "R10 jr");
        send(8'h20, 2, 0, 8, 0, 0, 0, 0, "R10 jr nz");
        send(8'h38, 2, 0, 8, 0, 3, 0, 0, "R10 jr c");
        // R13
        send(8'h31, 8, 3, 5, 0, 4, 0, 0, "R13 ld sp,imm");
        send(8'h09, 9, 2, 0, 0, 4, 0, 0, "R13 add hl,bc");
        send(8'h3A, 5, 7, 12, 0, 4, 0, 0, "R13 ld a,(hl-)");
        send(8'h12, 5, 10, 7, 0, 4, 0, 0, "R13 ld (de),a");
        send(8'h2B, 7, 2, 0, 0, 4, 0, 0, "R13 dec hl");
        send(8'h34, 3, 6, 0, 0, 4, 0, 0, "R13 inc (hl)");
        send(8'h2F, 12, 0, 0, 5, 4, 0, 0, "R13 unary");
        send(8'hF5, 16, 0, 4, 0, 4, 0, 0, "R13 push af");
        send(8'hC1, 17, 0, 0, 0, 4, 0, 0, "R13 pop bc");
        // R7
        send(8'hCB, 18, 0, 0, 0, 4, 0, 0, "R7 prefix");
        send(8'h37, 27, 7, 7, 6, 4, 0, 1, "R7 shift");
        send(8'hCB, 18, 0, 0, 0, 4, 0, 0, "R7 prefix");
        send(8'h7C, 28, 0, 4, 7, 4, 0, 1, "R7 bit test");
        send(8'hCB, 18, 0, 0, 0, 4, 0, 0, "R7 prefix");
        send(8'h86, 29, 6, 6, 0, 4, 0, 1, "R7 bit clear");
        send(8'hCB, 18, 0, 0, 0, 4, 0, 0, "R7 prefix");
        send(8'hFF, 30, 7, 7, 7, 4, 0, 1, "R7 bit set");
        // R8: prefix meets prefix, then back to primary
        send(8'hCB, 18, 0, 0, 0, 4, 0, 0, "R8 prefix");
        send(8'hCB, 30, 3, 3, 1, 4, 0, 1, "R8 cb as secondary");
        send(8'h00, 0, 0, 0, 0, 4, 0, 0, "R8 primary after");
        // R8: idle cycles keep the state
        send(8'hCB, 18, 0, 0, 0, 4, 0, 0, "R8 prefix");
        idle(3);
        send(8'h11, 27, 1, 1, 2, 4, 0, 1, "R8 held across idle");
        idle(2);
        // R12
        check(out_valid == 1'b0, "R12 idle out_valid", {35'h0, out_valid}, 36'h0);
        check(sb.size() == 0, "R12 all outputs seen", 36'(sb.size()), 36'h0);

        // R11: reset while armed
        send(8'hCB, 18, 0, 0, 0, 4, 0, 0, "R11 prefix");
        idle(1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R11 reset mid prefix", {35'h0, out_valid}, 36'h0);
        rst = 1'b0;
        send(8'h00, 0, 0, 0, 0, 4, 0, 0, "R11 primary after reset");
        idle(3);
        check(sb.size() == 0, "R12 queue drained", 36'(sb.size()), 36'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule